// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for every beat of one read or write burst in a synchronous DRAM column path. A column command (a start strobe or an interrupt strobe) supplies a start column, a burst length code and an order bit. From the next clock on, the block steps through the burst, one column per cycle. It raises a valid flag on every beat and a last flag on the final beat of a fixed-length burst.

A stop strobe ends the burst at once. A new column command may arrive on any cycle, including the final beat, and restarts generation from its own column. Full-page bursts use sequential order only. They wrap around the whole row and run until a stop or a new command arrives. A setting that asks for interleaved order with full-page length, or that uses a reserved length code, raises a one-cycle error flag and starts nothing.

Top module: `bcg_burst_gen`

## Requirements
- R1: While reset is asserted (sampled at a clock edge), and in the cycle after it, valid_o, last_o and err_o are 0.
- R2: Length codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. valid_o stays high for exactly that many consecutive cycles when no other command or stop arrives.
- R3: With burst_itl_i = 0, the burst counts upward inside the block of burst-length columns aligned to that length. It wraps from the top of that block to its bottom, and the bits above the block stay equal to the start column.
- R4: With burst_itl_i = 1, beat k carries the start column with its low log2(length) bits XORed with k. The higher bits stay unchanged.
- R5: Length code 7 with sequential order is a full-page burst. The column increases by one per beat modulo 1024, the burst never ends by itself, and last_o is never raised.
- R6: last_o is high only on the final beat of a fixed-length burst. If no command arrives in that cycle, valid_o is 0 in the next cycle.
- R7: A stop_i with no column command in the same cycle makes valid_o 0 from the next cycle.
- R8: An interrupt (intr_i) restarts the burst from intr_col_i in the next cycle. When several strobes coincide, the priority is interrupt, then start, then stop.
- R9: A column command whose setting is interleaved with code 7, or whose code is 4, 5 or 6, sets err_o for exactly the next cycle. It also drops valid_o in that cycle, and this ends any burst in progress.
- R10: A column command is accepted on every cycle, including the final beat of the previous burst, so bursts can run back to back with no gap.
- R11: The column given with an accepted command appears on col_o, with valid_o high, in the cycle after the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe for a new burst |
| start_col_i | input | 10 | Start column carried by start_i |
| intr_i | input | 1 | Interrupting column command |
| intr_col_i | input | 10 | Start column carried by intr_i |
| stop_i | input | 1 | Burst stop strobe |
| burst_len_i | input | 3 | Length code: 0=1, 1=2, 2=4, 3=8, 7=full page |
| burst_itl_i | input | 1 | Order: 0 sequential, 1 interleaved |
| col_o | output | 10 | Column of the current beat |
| valid_o | output | 1 | A beat is present on col_o |
| last_o | output | 1 | Final beat of a fixed-length burst |
| err_o | output | 1 | Previous command carried an illegal setting |

## Verification
The hardest case to reach is the wrap of a full-page burst past column 1023 while last_o stays low. The bench starts a full-page burst two columns below the top of the row and runs it for more than a full row, checking every beat, before it stops the burst. Other cases also depend on exact cycle alignment: strobes that coincide, and commands issued on the final beat. The bench drives these at the falling edge before the chosen rising edge.

// File: rtl/bcg_pkg.sv
// Package: shared length-code encoding for the burst column address generator.
// Assumes: codes outside this enum are reserved and are treated as illegal.
package bcg_pkg;
    typedef enum logic [2:0] {
        BL_ONE   = 3'd0,
        BL_TWO   = 3'd1,
        BL_FOUR  = 3'd2,
        BL_EIGHT = 3'd3,
        BL_PAGE  = 3'd7
    } blen_e;
endpackage

// File: rtl/bcg_len_decode.sv
// Length decoder: turns a length code and order bit into a wrap mask,
// a full-page flag and an illegal-setting flag.
// Assumes: COL_W >= 3 so that an eight-beat mask fits.
module bcg_len_decode #(
    parameter int COL_W = 10
) (
    input  logic [2:0]       len_code_i,
    input  logic             itl_i,
    output logic [COL_W-1:0] mask_o,
    output logic             full_o,
    output logic             illegal_o
);
    import bcg_pkg::*;

    blen_e code;
    assign code = blen_e'(len_code_i);

    // Mask of the address bits that move during the burst.
    always_comb begin
        unique case (code)
            BL_ONE:   mask_o = '0;
            BL_TWO:   mask_o = COL_W'(1);
            BL_FOUR:  mask_o = COL_W'(3);
            BL_EIGHT: mask_o = COL_W'(7);
            BL_PAGE:  mask_o = '1;
            default:  mask_o = '0;
        endcase
    end

    // Full-page detect and illegal-setting detect.
    always_comb begin
        full_o    = (code == BL_PAGE);
        illegal_o = !(code inside {BL_ONE, BL_TWO, BL_FOUR, BL_EIGHT, BL_PAGE})
                    || (full_o && itl_i);
    end
endmodule

// File: rtl/bcg_col_mix.sv
// Column mixer: forms the beat column from the latched start column, the
// beat index and the wrap mask. Bits under the mask follow the selected
// order; bits above it keep the start column.
// Assumes: beat_i never exceeds mask_i.
module bcg_col_mix #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             itl_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] sum;

    // Sequential candidate: start plus beat, carries cut by the mask per bit.
    always_comb sum = base_i + beat_i;

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        // Per-bit select between fixed start bit and the moving bit.
        always_comb begin
            if (!mask_i[b])
                col_o[b] = base_i[b];
            else if (itl_i)
                col_o[b] = base_i[b] ^ beat_i[b];
            else
                col_o[b] = sum[b];
        end
    end
endmodule

// File: rtl/bcg_seq_ctrl.sv
// Sequencer: holds the burst state (active flag, beat count, latched start
// column and setting) and applies command, stop and end-of-burst rules.
// Assumes: the caller has already resolved strobe priority into cmd_i/cmd_col_i.
module bcg_seq_ctrl #(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_i,
    input  logic             stop_i,
    input  logic             illegal_i,
    input  logic [COL_W-1:0] cmd_col_i,
    input  logic [COL_W-1:0] cmd_mask_i,
    input  logic             cmd_full_i,
    input  logic             cmd_itl_i,
    output logic             active_o,
    output logic [COL_W-1:0] beat_o,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] mask_o,
    output logic             itl_o,
    output logic             last_o,
    output logic             err_o
);
    logic full_q;

    // Final beat of a fixed-length burst.
    always_comb last_o = active_o && !full_q && (beat_o == mask_o);

    // Burst state update: command first, then stop, then stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            beat_o   <= '0;
            base_o   <= '0;
            mask_o   <= '0;
            itl_o    <= 1'b0;
            full_q   <= 1'b0;
            err_o    <= 1'b0;
        end else begin
            err_o <= cmd_i && illegal_i;
            if (cmd_i) begin
                active_o <= !illegal_i;
                beat_o   <= '0;
                base_o   <= cmd_col_i;
                mask_o   <= cmd_mask_i;
                itl_o    <= cmd_itl_i;
                full_q   <= cmd_full_i;
            end else if (stop_i) begin
                active_o <= 1'b0;
            end else if (active_o) begin
                if (last_o)
                    active_o <= 1'b0;
                else
                    beat_o <= beat_o + COL_W'(1);
            end
        end
    end
endmodule

// File: rtl/bcg_burst_gen.sv
// Top: burst column address generator. Resolves strobe priority
// (interrupt > start > stop), decodes the setting of the accepted command
// and produces one column per cycle of the burst.
// Assumes: settings are sampled only with a column command.
module bcg_burst_gen #(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic             intr_i,
    input  logic [COL_W-1:0] intr_col_i,
    input  logic             stop_i,
    input  logic [2:0]       burst_len_i,
    input  logic             burst_itl_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             err_o
);
    logic             cmd;
    logic [COL_W-1:0] cmd_col;
    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic             dec_illegal;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] mask;
    logic             itl;

    // Strobe priority: interrupt column wins over start column.
    always_comb begin
        cmd     = start_i || intr_i;
        cmd_col = intr_i ? intr_col_i : start_col_i;
    end

    bcg_len_decode #(.COL_W(COL_W)) u_dec (
        .len_code_i (burst_len_i),
        .itl_i      (burst_itl_i),
        .mask_o     (dec_mask),
        .full_o     (dec_full),
        .illegal_o  (dec_illegal)
    );

    bcg_seq_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_i      (cmd),
        .stop_i     (stop_i),
        .illegal_i  (dec_illegal),
        .cmd_col_i  (cmd_col),
        .cmd_mask_i (dec_mask),
        .cmd_full_i (dec_full),
        .cmd_itl_i  (burst_itl_i),
        .active_o   (valid_o),
        .beat_o     (beat),
        .base_o     (base),
        .mask_o     (mask),
        .itl_o      (itl),
        .last_o     (last_o),
        .err_o      (err_o)
    );

    bcg_col_mix #(.COL_W(COL_W)) u_mix (
        .base_i (base),
        .beat_i (beat),
        .mask_i (mask),
        .itl_i  (itl),
        .col_o  (col_o)
    );
endmodule

// File: rtl/bcg_burst_gen_chk.sv
// Checker: port-level properties of the burst generator, bound to the top.
module bcg_burst_gen_chk #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic             intr_i,
    input logic [COL_W-1:0] intr_col_i,
    input logic             stop_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o,
    input logic             err_o
);
    // R7
    stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i && !intr_i) |=> !valid_o);

    // R6
    last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    // R6
    last_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i && !intr_i) |=> !valid_o);

    // R9
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !valid_o);

    // R11
    start_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !intr_i) |=> (err_o || (valid_o && col_o == $past(start_col_i))));

    // R8
    intr_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intr_i |=> (err_o || (valid_o && col_o == $past(intr_col_i))));
endmodule

bind bcg_burst_gen bcg_burst_gen_chk #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .intr_i      (intr_i),
    .intr_col_i  (intr_col_i),
    .stop_i      (stop_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o),
    .err_o       (err_o)
);

// File: tb/bcg_burst_gen_tb.sv
module bcg_burst_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [9:0] start_col_i = '0;
    logic       intr_i = 1'b0;
    logic [9:0] intr_col_i = '0;
    logic       stop_i = 1'b0;
    logic [2:0] burst_len_i = '0;
    logic       burst_itl_i = 1'b0;
    logic [9:0] col_o;
    logic       valid_o, last_o, err_o;

    int checks = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bcg_burst_gen u_dut (
        .clk(clk), .rst_n(rst_n),
        .start_i(start_i), .start_col_i(start_col_i),
        .intr_i(intr_i), .intr_col_i(intr_col_i),
        .stop_i(stop_i), .burst_len_i(burst_len_i), .burst_itl_i(burst_itl_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
    );

    typedef struct packed {
        logic            itl;
        logic [2:0]      code;
        logic [9:0]      col;
        logic [3:0]      n;
        logic [0:7][9:0] exp;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{1'b0, 3'd0, 10'h123, 4'd1, '{10'h123, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0}},
        '{1'b0, 3'd1, 10'h005, 4'd2, '{10'h005, 10'h004, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0}},
        '{1'b0, 3'd2, 10'h00E, 4'd4, '{10'h00E, 10'h00F, 10'h00C, 10'h00D, 10'h0, 10'h0, 10'h0, 10'h0}},
        '{1'b0, 3'd3, 10'h3FD, 4'd8, '{10'h3FD, 10'h3FE, 10'h3FF, 10'h3F8, 10'h3F9, 10'h3FA, 10'h3FB, 10'h3FC}},
        '{1'b1, 3'd2, 10'h0A6, 4'd4, '{10'h0A6, 10'h0A7, 10'h0A4, 10'h0A5, 10'h0, 10'h0, 10'h0, 10'h0}},
        '{1'b1, 3'd3, 10'h015, 4'd8, '{10'h015, 10'h014, 10'h017, 10'h016, 10'h011, 10'h010, 10'h013, 10'h012}},
        '{1'b1, 3'd1, 10'h201, 4'd2, '{10'h201, 10'h200, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0}},
        '{1'b1, 3'd0, 10'h07F, 4'd1, '{10'h07F, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0}},
        '{1'b0, 3'd3, 10'h010, 4'd8, '{10'h010, 10'h011, 10'h012, 10'h013, 10'h014, 10'h015, 10'h016, 10'h017}}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        start_i = 1'b0; intr_i = 1'b0; stop_i = 1'b0;
    endtask

    task automatic go(input logic itl, input logic [2:0] code, input logic [9:0] col);
        start_i = 1'b1; start_col_i = col; burst_itl_i = itl; burst_len_i = code;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet during and right after reset
        chk(!valid_o && !last_o && !err_o, "R1 in reset", {valid_o, last_o, err_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!valid_o && !last_o && !err_o, "R1 after reset", {valid_o, last_o, err_o}, 0);

        // R2 R3 R4 R6 R11: walk the vector table
        for (int v = 0; v < 9; v++) begin
            go(VECS[v].itl, VECS[v].code, VECS[v].col);
            @(negedge clk);
            idle();
            for (int k = 0; k < int'(VECS[v].n); k++) begin
                chk(valid_o && col_o == VECS[v].exp[k] && last_o == (k == int'(VECS[v].n) - 1),
                    VECS[v].itl ? "R4 beat" : "R3 beat",
                    {valid_o, last_o, col_o}, {1'b1, k == int'(VECS[v].n) - 1, VECS[v].exp[k]});
                @(negedge clk);
            end
            chk(!valid_o, "R2 burst length end", valid_o, 0);
        end

        // R5: full page wraps past 1023 without last, then R7 stop
        begin
            bit ok = 1'b1;
            logic [9:0] bad_col = '0;
            go(1'b0, 3'd7, 10'h3FE);
            @(negedge clk);
            idle();
            for (int k = 0; k < 1030; k++) begin
                if (!(valid_o && !last_o && col_o == 10'(10'h3FE + k))) begin
                    if (ok) bad_col = col_o;
                    ok = 1'b0;
                end
                @(negedge clk);
            end
            chk(ok, "R5 full page wrap", bad_col, 0);
            stop_i = 1'b1;
            @(negedge clk);
            idle();
            chk(!valid_o, "R7 stop full page", valid_o, 0);
        end

        // R7: stop in the middle of an eight-beat burst
        go(1'b0, 3'd3, 10'h040);
        @(negedge clk); idle();
        @(negedge clk);
        chk(valid_o && col_o == 10'h041, "R7 pre-stop beat", col_o, 10'h041);
        stop_i = 1'b1;
        @(negedge clk); idle();
        chk(!valid_o, "R7 stop mid burst", valid_o, 0);

        // R8: interrupt beats start in the same cycle, then continues in its own order
        go(1'b0, 3'd3, 10'h100);
        @(negedge clk); idle();
        @(negedge clk);
        intr_i = 1'b1; intr_col_i = 10'h0F3;
        start_i = 1'b1; start_col_i = 10'h2AA; burst_len_i = 3'd3; burst_itl_i = 1'b0;
        @(negedge clk); idle();
        chk(valid_o && col_o == 10'h0F3, "R8 interrupt column", col_o, 10'h0F3);
        @(negedge clk);
        chk(valid_o && col_o == 10'h0F4, "R8 interrupt next beat", col_o, 10'h0F4);

        // R8: start beats stop in the same cycle
        go(1'b0, 3'd0, 10'h055);
        stop_i = 1'b1;
        @(negedge clk); idle();
        chk(valid_o && last_o && col_o == 10'h055, "R8 start over stop", {valid_o, last_o, col_o}, {2'b11, 10'h055});
        @(negedge clk);
        chk(!valid_o, "R6 idle after last", valid_o, 0);

        // R9: interleaved full page is illegal
        go(1'b1, 3'd7, 10'h010);
        @(negedge clk); idle();
        chk(err_o && !valid_o, "R9 itl full page", {err_o, valid_o}, 2'b10);
        @(negedge clk);
        chk(!err_o && !valid_o, "R9 err one cycle", {err_o, valid_o}, 2'b00);

        // R9: reserved code during a running burst ends it
        go(1'b0, 3'd3, 10'h000);
        @(negedge clk);
        go(1'b0, 3'd5, 10'h020);
        @(negedge clk); idle();
        chk(err_o && !valid_o, "R9 reserved code", {err_o, valid_o}, 2'b10);

        // R10: new command on the final beat, no gap
        go(1'b0, 3'd1, 10'h000);
        @(negedge clk); idle();
        @(negedge clk);
        chk(valid_o && last_o && col_o == 10'h001, "R10 final beat", {valid_o, last_o, col_o}, {2'b11, 10'h001});
        go(1'b0, 3'd0, 10'h300);
        @(negedge clk); idle();
        chk(valid_o && last_o && col_o == 10'h300, "R10 back to back", {valid_o, last_o, col_o}, {2'b11, 10'h300});
        @(negedge clk);
        chk(!valid_o, "R10 idle", valid_o, 0);

        // R1: reset in the middle of a burst
        go(1'b0, 3'd7, 10'h000);
        @(negedge clk); idle();
        rst_n = 1'b0;
        @(negedge clk);
        chk(!valid_o && !last_o && !err_o, "R1 reset mid burst", {valid_o, last_o, err_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end
endmodule